// File: doc/BRIEF.md
# Timer Increment Trim Calculator

This block works out the per-cycle increment of a nanosecond time counter. In its initialise mode it takes the nominal frequency of the timer clock in hertz. From that it derives a base increment made of an integer nanosecond part and a 16-bit binary fraction of a nanosecond, and it keeps that base. In its trim mode it takes a signed frequency correction in scaled parts per million. It scales the stored base word by that correction and presents the corrected increment. The base itself is left untouched, so successive trims never accumulate.

The work is sequential. A restoring shift-subtract divider produces one quotient bit per cycle and serves all three divisions. A shift-add multiplier forms the product of the correction magnitude and the base word. A caller raises `start_i` for one cycle with the mode and operand and waits for `done_o`. The output pair changes only in that cycle. A start that arrives while a computation is running is dropped. Writing the result into the time counter, and choosing the correction, belong to the surrounding logic.

Top module: `trim_calc`

## Requirements
- R1: While reset is held and after its release, `inc_ns_o` and `inc_frac_o` are zero and `done_o` and `err_o` are low.
- R2: An initialise request (`mode_i` = 0) with a nonzero rate sets `inc_ns_o` to the low 8 bits of floor(1,000,000,000 / rate), and the same value becomes the stored base ns.
- R3: In that request the fraction is floor(remainder × 65536 / rate), where remainder is 1,000,000,000 mod rate; it is zero when the remainder is zero. The base word is ns × 65536 + fraction.
- R4: An initialise request with rate 0 raises `done_o` together with `err_o` exactly two cycles after the accepting edge. It leaves the outputs and the stored base unchanged.
- R5: A trim request (`mode_i` = 1) with a non-negative `trim_i` outputs base + corr. Here corr = floor((|trim| × base + 500,000) / 65536) / 1,000,000, with the integer division taken last.
- R6: A negative `trim_i` uses its magnitude (so -2^31 gives 2^31) and outputs base − corr. The 24-bit result wraps modulo 2^24. `inc_ns_o` is result bits 23:16 and `inc_frac_o` is bits 15:0.
- R7: Each trim is computed from the stored base, not from the last trimmed output, and a trim never alters the base.
- R8: `done_o` pulses high for exactly one cycle per accepted request. It is never high in two consecutive cycles, and `err_o` is high only together with `done_o`.
- R9: A `start_i` pulse while a computation is running is ignored: it neither changes the result of the running request nor produces a later `done_o`.
- R10: `inc_ns_o` and `inc_frac_o` change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted only while idle |
| mode_i | input | 1 | 0 = initialise from rate, 1 = apply trim |
| rate_i | input | 32 | Timer clock frequency in hertz |
| trim_i | input | 32 | Signed scaled-ppm correction (two's complement) |
| inc_ns_o | output | 8 | Integer nanosecond increment |
| inc_frac_o | output | 16 | Sub-nanosecond increment in 1/65536 ns |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With `done_o`: request rejected because rate was zero |

## Verification
The bench builds the block with its default widths: a 32-bit rate, a 32-bit trim, an 8-bit ns field and a 16-bit fraction. It therefore uses the same 1e9 and 1e6 constants a real clock setup would. These widths make it possible to reach a rate of 1, whose quotient overflows the ns field and is truncated, and a rate above 1e9, which gives a zero ns field and a pure fraction. The full-scale negative trim of -2^31 and the largest positive trim can also be driven. The reference model follows the outputs on every cycle against 64-bit integer arithmetic. It also pokes `start_i` in the middle of a running request to confirm that the poke is dropped.

// File: rtl/tfc_pkg.sv
// Shared definitions for the timer increment trim calculator.
// Assumes: mode encoding 0 = initialise, 1 = trim.
package tfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERR,
        ST_DIV_NS,
        ST_DIV_FR,
        ST_MUL,
        ST_DIV_PPM
    } tfc_state_e;

    localparam logic MODE_INIT = 1'b0;
    localparam logic MODE_TRIM = 1'b1;
endpackage

// File: rtl/tfc_divider.sv
// Restoring shift-subtract divider: one quotient bit per cycle, DW cycles
// per division. Assumes divisor is nonzero and go is raised only when idle.
module tfc_divider #(
    parameter int DW = 48,
    parameter int VW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [DW-1:0] quot,
    output logic [VW-1:0] rmd,
    output logic          valid
);
    localparam int CW = $clog2(DW + 1);

    logic [VW-1:0] rem_q;
    logic [DW-1:0] quo_q;
    logic [VW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [VW:0]   trial;
    logic [VW:0]   diff;
    logic          fits;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        fits  = trial >= {1'b0, dvs_q};
        diff  = trial - {1'b0, dvs_q};
    end

    // Load on go, then shift one dividend bit per cycle into the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[VW-1:0] : trial[VW-1:0];
                quo_q <= {quo_q[DW-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;
    assign rmd  = rem_q;
endmodule

// File: rtl/tfc_multiplier.sv
// Shift-add unsigned multiplier: one multiplier bit per cycle, BW cycles.
// Assumes go is raised only when idle.
module tfc_multiplier #(
    parameter int AW = 32,
    parameter int BW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-1:0]    a,
    input  logic [BW-1:0]    b,
    output logic [AW+BW-1:0] prod,
    output logic             valid
);
    localparam int PW = AW + BW;
    localparam int CW = $clog2(BW + 1);

    logic [PW-1:0] acc_q;
    logic [PW-1:0] mcand_q;
    logic [BW-1:0] mplier_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Accumulate the shifted multiplicand for each set multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                acc_q    <= '0;
                mcand_q  <= PW'(a);
                mplier_q <= b;
                cnt_q    <= CW'(BW);
                run_q    <= 1'b1;
            end else if (run_q) begin
                if (mplier_q[0]) acc_q <= acc_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;
endmodule

// File: rtl/trim_calc.sv
// Timer increment trim calculator. Initialise mode derives the base
// increment from the clock rate; trim mode scales the stored base by a signed
// scaled-ppm value. Assumes one request at a time; starts while busy are
// dropped.
module trim_calc #(
    parameter int          RATE_W     = 32,
    parameter int          PPM_W      = 32,
    parameter int          NS_W       = 8,
    parameter int          FRAC_W     = 16,
    parameter int unsigned NS_PER_SEC = 1_000_000_000,
    parameter int unsigned PPM_SCALE  = 1_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    mode_i,
    input  logic [RATE_W-1:0]       rate_i,
    input  logic signed [PPM_W-1:0] trim_i,
    output logic [NS_W-1:0]         inc_ns_o,
    output logic [FRAC_W-1:0]       inc_frac_o,
    output logic                    done_o,
    output logic                    err_o
);
    import tfc_pkg::*;

    localparam int WORD_W   = NS_W + FRAC_W;
    localparam int PROD_W   = PPM_W + WORD_W;
    localparam int INIT_DW  = RATE_W + FRAC_W;
    localparam int RND_DW   = PROD_W + 1 - FRAC_W;
    localparam int DIV_DW   = (INIT_DW > RND_DW) ? INIT_DW : RND_DW;
    localparam int unsigned ROUND_HALF = PPM_SCALE / 2;

    tfc_state_e          state_q;
    logic [WORD_W-1:0]   base_q;
    logic [NS_W-1:0]     ns_hold_q;
    logic [RATE_W-1:0]   rate_q;
    logic                neg_q;
    logic                busy;
    logic                accept;

    logic                div_go;
    logic [DIV_DW-1:0]   div_dvd;
    logic [RATE_W-1:0]   div_dvs;
    logic [DIV_DW-1:0]   div_quot;
    logic [RATE_W-1:0]   div_rmd;
    logic                div_valid;

    logic                mul_go;
    logic [PPM_W-1:0]    mag;
    logic [PROD_W-1:0]   mul_prod;
    logic                mul_valid;
    logic [PROD_W:0]     rnd_sum;
    logic [WORD_W-1:0]   trimmed;
    logic                unused_bits;

    assign busy   = (state_q != ST_IDLE);
    assign accept = start_i && !busy;

    // Magnitude of the trim, rounding sum and trimmed word.
    always_comb begin
        mag     = trim_i[PPM_W-1] ? (~$unsigned(trim_i) + PPM_W'(1)) : $unsigned(trim_i);
        rnd_sum = {1'b0, mul_prod} + (PROD_W+1)'(ROUND_HALF);
        trimmed = neg_q ? (base_q - div_quot[WORD_W-1:0])
                        : (base_q + div_quot[WORD_W-1:0]);
    end

    assign unused_bits = ^div_quot[DIV_DW-1:WORD_W];

    // Launch the shared divider and the multiplier from the controller state.
    always_comb begin
        div_go  = 1'b0;
        div_dvd = '0;
        div_dvs = '0;
        mul_go  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept && mode_i == MODE_INIT && rate_i != '0) begin
                    div_go  = 1'b1;
                    div_dvd = DIV_DW'(NS_PER_SEC);
                    div_dvs = rate_i;
                end
                if (accept && mode_i == MODE_TRIM) mul_go = 1'b1;
            end
            ST_DIV_NS: begin
                if (div_valid && div_rmd != '0) begin
                    div_go  = 1'b1;
                    div_dvd = DIV_DW'({div_rmd, {FRAC_W{1'b0}}});
                    div_dvs = rate_q;
                end
            end
            ST_MUL: begin
                if (mul_valid) begin
                    div_go  = 1'b1;
                    div_dvd = DIV_DW'(rnd_sum >> FRAC_W);
                    div_dvs = RATE_W'(PPM_SCALE);
                end
            end
            default: ;
        endcase
    end

    tfc_divider #(.DW(DIV_DW), .VW(RATE_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .quot     (div_quot),
        .rmd      (div_rmd),
        .valid    (div_valid)
    );

    tfc_multiplier #(.AW(PPM_W), .BW(WORD_W)) i_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (mag),
        .b     (base_q),
        .prod  (mul_prod),
        .valid (mul_valid)
    );

    // Sequence the request and register base, outputs and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            ns_hold_q  <= '0;
            rate_q     <= '0;
            neg_q      <= 1'b0;
            inc_ns_o   <= '0;
            inc_frac_o <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (mode_i == MODE_INIT) begin
                            rate_q  <= rate_i;
                            state_q <= (rate_i == '0) ? ST_ERR : ST_DIV_NS;
                        end else begin
                            neg_q   <= trim_i[PPM_W-1];
                            state_q <= ST_MUL;
                        end
                    end
                end
                ST_ERR: begin
                    done_o  <= 1'b1;
                    err_o   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_DIV_NS: begin
                    if (div_valid) begin
                        ns_hold_q <= div_quot[NS_W-1:0];
                        if (div_rmd == '0) begin
                            base_q     <= {div_quot[NS_W-1:0], {FRAC_W{1'b0}}};
                            inc_ns_o   <= div_quot[NS_W-1:0];
                            inc_frac_o <= '0;
                            done_o     <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            state_q <= ST_DIV_FR;
                        end
                    end
                end
                ST_DIV_FR: begin
                    if (div_valid) begin
                        base_q     <= {ns_hold_q, div_quot[FRAC_W-1:0]};
                        inc_ns_o   <= ns_hold_q;
                        inc_frac_o <= div_quot[FRAC_W-1:0];
                        done_o     <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                ST_MUL: begin
                    if (mul_valid) state_q <= ST_DIV_PPM;
                end
                ST_DIV_PPM: begin
                    if (div_valid) begin
                        inc_ns_o   <= trimmed[WORD_W-1:FRAC_W];
                        inc_frac_o <= trimmed[FRAC_W-1:0];
                        done_o     <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tfc_checker.sv
// Protocol checks for trim_calc, attached by bind. Observes ports and the
// controller's busy flag.
module tfc_checker #(
    parameter int RATE_W = 32,
    parameter int NS_W   = 8,
    parameter int FRAC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mode_i,
    input logic [RATE_W-1:0] rate_i,
    input logic              busy,
    input logic [NS_W-1:0]   inc_ns_o,
    input logic [FRAC_W-1:0] inc_frac_o,
    input logic              done_o,
    input logic              err_o
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(inc_ns_o) && $stable(inc_frac_o)));

    // R4
    zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && !mode_i && rate_i == '0) |-> ##2 (done_o && err_o));

    // R4
    zero_rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(inc_ns_o) && $stable(inc_frac_o)));
endmodule

bind trim_calc tfc_checker #(
    .RATE_W (RATE_W),
    .NS_W   (NS_W),
    .FRAC_W (FRAC_W)
) i_tfc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .rate_i     (rate_i),
    .busy       (busy),
    .inc_ns_o   (inc_ns_o),
    .inc_frac_o (inc_frac_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/test_trim_calc.sv
// Bench for trim_calc: behavioural 64-bit reference model compared each cycle.
module test_trim_calc;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               mode = 1'b0;
    logic [31:0]        rate = '0;
    logic signed [31:0] trim = '0;
    logic [7:0]         inc_ns;
    logic [15:0]        inc_frac;
    logic               done;
    logic               err;

    int total = 0;
    int bad = 0;
    int ops = 0;
    int dones = 0;
    int wait_cnt = 0;
    bit finished = 0;

    // Reference model state
    bit                m_busy = 0;
    longint unsigned   m_base = 0;
    longint unsigned   m_ns = 0;
    longint unsigned   m_frac = 0;
    longint unsigned   e_ns = 0;
    longint unsigned   e_frac = 0;
    longint unsigned   e_base = 0;
    bit                e_err = 0;
    bit                e_setbase = 0;
    string             m_req = "R1";

    always #4ns clk = ~clk;

    trim_calc i_trim_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .mode_i     (mode),
        .rate_i     (rate),
        .trim_i     (trim),
        .inc_ns_o   (inc_ns),
        .inc_frac_o (inc_frac),
        .done_o     (done),
        .err_o      (err)
    );

    task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Model: accept a request on a rising edge while idle and compute the result.
    always @(posedge clk) begin
        if (rst_n && start && !m_busy) begin
            longint unsigned q, r, f, mag, corr, w;
            m_busy = 1;
            wait_cnt = 0;
            e_err = 0;
            e_setbase = 0;
            if (!mode) begin
                if (rate == 0) begin
                    e_err = 1;
                    e_ns = m_ns;
                    e_frac = m_frac;
                end else begin
                    q = 64'd1000000000 / rate;
                    r = 64'd1000000000 % rate;
                    f = (r != 0) ? ((r << 16) / rate) : 0;
                    e_ns = q & 255;
                    e_frac = f & 65535;
                    e_base = (e_ns << 16) | e_frac;
                    e_setbase = 1;
                end
            end else begin
                mag = (trim < 0) ? longint'(-longint'(trim)) : longint'(trim);
                corr = ((mag * m_base + 500000) >> 16) / 1000000;
                w = (trim < 0) ? (m_base - corr) : (m_base + corr);
                w = w & 24'hFFFFFF;
                e_ns = w >> 16;
                e_frac = w & 65535;
            end
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                dones++;
                if (!m_busy) begin
                    check("R8", "done without request", 1, 0);
                end else begin
                    check(m_req, "ns", inc_ns, e_ns);
                    check(m_req, "frac", inc_frac, e_frac);
                    check(m_req, "err", err, e_err);
                    m_ns = e_ns;
                    m_frac = e_frac;
                    if (e_setbase) m_base = e_base;
                    m_busy = 0;
                end
            end else begin
                check("R8", "err without done", err, 0);
                check("R10", "ns held", inc_ns, m_ns);
                check("R10", "frac held", inc_frac, m_frac);
            end
            if (m_busy) begin
                wait_cnt++;
                if (wait_cnt > 1000) begin
                    check(m_req, "watchdog: no done", 0, 1);
                    finish_run();
                end
            end
        end
    end

    task automatic run_op(bit md, logic [31:0] rt, logic signed [31:0] tr, string req, bit poke);
        @(negedge clk);
        m_req = req;
        mode = md;
        rate = rt;
        trim = tr;
        start = 1;
        ops++;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (5) @(negedge clk);
            mode = 1'b0;
            rate = 32'd0;
            start = 1;
            @(negedge clk);
            start = 0;
            mode = 1'b1;
            trim = 32'sd123456789;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        check("WD", "global watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check("R1", "ns in reset", inc_ns, 0);
        check("R1", "frac in reset", inc_frac, 0);
        check("R1", "done in reset", done, 0);
        check("R1", "err in reset", err, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "ns after reset", inc_ns, 0);
        check("R1", "done after reset", done, 0);

        run_op(0, 32'd125_000_000, 0, "R2", 0);       // ns 8, zero remainder
        run_op(0, 32'd300_000_000, 0, "R3", 0);       // ns 3, fraction from remainder
        run_op(0, 32'd0, 0, "R4", 0);                 // rejected, outputs kept
        run_op(1, 0, 32'sd6553600, "R5", 0);          // +100 ppm
        run_op(1, 0, -32'sd6553600, "R6", 0);         // -100 ppm
        run_op(1, 0, 32'sd0, "R7", 0);                // back to stored base
        run_op(0, 32'd1, 0, "R2", 0);                 // quotient truncated to 8 bits
        run_op(0, 32'hFFFF_FFFF, 0, "R3", 0);         // pure fraction
        run_op(1, 0, 32'sh8000_0000, "R6", 0);        // full-scale negative
        run_op(1, 0, 32'sh7FFF_FFFF, "R5", 0);        // full-scale positive
        run_op(1, 0, 32'sd0, "R7", 0);                // base untouched by trims
        run_op(0, 32'd250_000_000, 0, "R9", 1);       // pokes dropped while busy
        run_op(1, 0, 32'sd33554432, "R9", 1);         // pokes dropped during trim
        run_op(0, 32'd0, 0, "R4", 0);
        run_op(1, 0, -32'sd1000, "R7", 0);

        repeat (20) @(negedge clk);
        check("R8", "one done per request", dones, ops);
        finish_run();
    end
endmodule